// File: doc/BRIEF.md
# Wait-state memory bus sequencer

The sequencer sits between a CPU data port and a single memory bus. It takes one request of 1, 2 or 4 bytes and carries it out as a series of bus cycles. Each bus cycle runs for one clock plus a programmable number of wait states. The bus works either 8 bits wide or 16 bits wide. A request wider than the bus, or one that straddles an even-address boundary on the 16-bit bus, is split into several bus cycles. Read bytes are gathered into one little-endian word.

The bus width and the wait-state count are inputs. They are sampled once, when a request is accepted. An aligned access therefore takes (wait + 1) × ceil(bytes / bus bytes) clocks of bus activity. An unaligned access on the 16-bit bus pays for the extra leading or trailing byte cycle.

Top module: `ws_bus_seq`

## Requirements
- R1: While reset is asserted and when it is released: `ready_o`, `mem_cyc_o`, `mem_we_o` and `mem_be_o` are 0. Whenever `mem_cyc_o` is 0, `mem_be_o` is 0 and `mem_we_o` is 0.
- R2: Every bus cycle holds `mem_addr_o`, `mem_be_o`, `mem_we_o` and `mem_wdata_o` steady for exactly W+1 clocks, where W is the `wait_i` value sampled at acceptance. The strobe is never 0 during a bus cycle.
- R3: With `wide_i`=0 (8-bit bus), an N-byte access is N bus cycles at ascending byte addresses addr..addr+N-1. Each uses `mem_be_o`=2'b01 and the low lane `[7:0]`.
- R4: With `wide_i`=1 (16-bit bus), a byte pair at an even address is a single bus cycle with `mem_be_o`=2'b11 at that even address. A lone byte at an even address uses `mem_be_o`=2'b01 on lane `[7:0]`. An aligned access takes ceil(N/2) bus cycles.
- R5: On the 16-bit bus, a byte at an odd address X is a bus cycle at address X-1 with `mem_be_o`=2'b10 on lane `[15:8]`. A 2-byte access at an odd address takes 2 bus cycles, and a 4-byte access at an odd address takes 3 (single, pair, single).
- R6: `size_i` encodes 2'b00 = 1 byte, 2'b01 = 2 bytes, 2'b10 = 4 bytes, and 2'b11 acts as 4 bytes. Byte k of `wdata_i`/`rdata_o` (bits 8k+7:8k) belongs to address addr+k. Read bytes above the access size return 0.
- R7: `ready_o` is high for exactly one clock, in the clock right after the last bus cycle. No bus cycle runs in that clock, and `rdata_o` holds the read result in it.
- R8: From the accepting clock edge to `ready_o` there are exactly P×(W+1) clocks with `mem_cyc_o` high, where P is the bus-cycle count from R3–R5.
- R9: Changing `wait_i` or `wide_i` after a request is accepted has no effect on that access.
- R10: `req_i` is accepted only while neither a bus cycle nor `ready_o` is active. A request held high through an access, including its `ready_o` clock, produces that single access only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when the sequencer is idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the lowest byte |
| size_i | input | 2 | Access size code (R6) |
| wdata_i | input | 32 | Write data, little-endian |
| wide_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| wait_i | input | WS_W | Wait states per bus cycle |
| ready_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 32 | Assembled read data |
| mem_cyc_o | output | 1 | Bus cycle in progress |
| mem_we_o | output | 1 | Bus write enable |
| mem_addr_o | output | ADDR_W | Bus byte address (even on 16-bit bus) |
| mem_be_o | output | 2 | Byte-lane strobes |
| mem_wdata_o | output | 16 | Bus write data |
| mem_rdata_i | input | 16 | Bus read data, sampled in the last clock of each bus cycle |

## Verification
Two events can land in the same clock. The ready pulse can coincide with a request input that is still asserted. A change of the wait or width setting can arrive while a bus cycle is counting down its wait states. The bench provokes the first case by holding the request high through a whole access and its ready clock. It then confirms that no bus cycle appears unless the scoreboard expects one. It provokes the second case by flipping the wait count and the bus width in the clock after acceptance. The monitor then judges every observed bus cycle against the length and lane layout predicted from the settings that were sampled at acceptance.

// File: rtl/ws_seq_pkg.sv
package ws_seq_pkg;
  localparam int CPU_BYTES = 4;
  localparam int BUS_BYTES = 2;
  localparam int IDX_W     = $clog2(CPU_BYTES);
  localparam int CNT_W     = IDX_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_DONE} seq_st_e;

  function automatic logic [CNT_W-1:0] size_to_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return CNT_W'(1);
      2'd1:    return CNT_W'(2);
      default: return CNT_W'(CPU_BYTES);
    endcase
  endfunction
endpackage

// File: rtl/ws_wait_cnt.sv
module ws_wait_cnt #(
  parameter int WS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [WS_W-1:0] lim_i,
  output logic            last_o
);
  logic [WS_W-1:0] cnt_q;

  assign last_o = en_i && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (last_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + WS_W'(1);
  end
endmodule

// File: rtl/ws_piece_plan.sv
module ws_piece_plan import ws_seq_pkg::*; #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [CNT_W-1:0]  left_i,
  input  logic              wide_i,
  output logic              two_o,
  output logic              lane_o,
  output logic [1:0]        be_o,
  output logic [ADDR_W-1:0] maddr_o
);
  // one bus cycle: a single byte, or an even-aligned pair on the wide bus
  always_comb begin
    two_o   = 1'b0;
    lane_o  = 1'b0;
    be_o    = 2'b01;
    maddr_o = cur_i;
    if (wide_i) begin
      if (cur_i[0]) begin
        lane_o  = 1'b1;
        be_o    = 2'b10;
        maddr_o = {cur_i[ADDR_W-1:1], 1'b0};
      end else if (left_i >= CNT_W'(BUS_BYTES)) begin
        two_o = 1'b1;
        be_o  = 2'b11;
      end
    end
  end
endmodule

// File: rtl/ws_rd_asm.sv
module ws_rd_asm import ws_seq_pkg::*; (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   cap_i,
  input  logic                   two_i,
  input  logic                   lane_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [15:0]            rdata_i,
  output logic [CPU_BYTES*8-1:0] data_o
);
  logic [IDX_W:0] lo_pos, hi_pos;
  assign lo_pos = {1'b0, idx_i};
  assign hi_pos = lo_pos + (IDX_W+1)'(1);

  for (genvar g = 0; g < CPU_BYTES; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      b_q <= '0;
      else if (clr_i)   b_q <= '0;
      else if (cap_i) begin
        if (lo_pos == (IDX_W+1)'(g))
          b_q <= (two_i || !lane_i) ? rdata_i[7:0] : rdata_i[15:8];
        else if (two_i && hi_pos == (IDX_W+1)'(g))
          b_q <= rdata_i[15:8];
      end
    end
    assign data_o[8*g +: 8] = b_q;
  end
endmodule

// File: rtl/ws_bus_seq.sv
module ws_bus_seq import ws_seq_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int WS_W   = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [1:0]             size_i,
  input  logic [CPU_BYTES*8-1:0] wdata_i,
  input  logic                   wide_i,
  input  logic [WS_W-1:0]        wait_i,
  output logic                   ready_o,
  output logic [CPU_BYTES*8-1:0] rdata_o,
  output logic                   mem_cyc_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [1:0]             mem_be_o,
  output logic [15:0]            mem_wdata_o,
  input  logic [15:0]            mem_rdata_i
);
  seq_st_e                st_q;
  logic [ADDR_W-1:0]      cur_q;
  logic [CNT_W-1:0]       left_q;
  logic [IDX_W-1:0]       idx_q;
  logic                   we_q, wide_q;
  logic [WS_W-1:0]        ws_q;
  logic [CPU_BYTES*8-1:0] wdata_q;

  logic accept, in_bus, last_clk, piece_end;
  logic two, lane;
  logic [1:0] be;
  logic [ADDR_W-1:0] maddr;
  logic [CNT_W-1:0] step;
  logic [CPU_BYTES*8-1:0] wsh;

  assign accept    = (st_q == ST_IDLE) && req_i;
  assign in_bus    = (st_q == ST_BUS);
  assign piece_end = in_bus && last_clk;
  assign step      = two ? CNT_W'(2) : CNT_W'(1);

  ws_piece_plan #(.ADDR_W(ADDR_W)) u_plan (
    .cur_i(cur_q), .left_i(left_q), .wide_i(wide_q),
    .two_o(two), .lane_o(lane), .be_o(be), .maddr_o(maddr)
  );

  ws_wait_cnt #(.WS_W(WS_W)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(in_bus), .lim_i(ws_q), .last_o(last_clk)
  );

  ws_rd_asm u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept),
    .cap_i(piece_end && !we_q), .two_i(two), .lane_i(lane),
    .idx_i(idx_q), .rdata_i(mem_rdata_i), .data_o(rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      left_q  <= '0;
      idx_q   <= '0;
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      ws_q    <= '0;
      wdata_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_BUS;
          cur_q   <= addr_i;
          left_q  <= size_to_bytes(size_i);
          idx_q   <= '0;
          we_q    <= we_i;
          wide_q  <= wide_i;
          ws_q    <= wait_i;
          wdata_q <= wdata_i;
        end
        ST_BUS: if (piece_end) begin
          cur_q  <= cur_q + ADDR_W'(step);
          left_q <= left_q - step;
          idx_q  <= idx_q + IDX_W'(step);
          if (left_q == step) st_q <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wsh = wdata_q >> {idx_q, 3'b000};

  assign ready_o     = (st_q == ST_DONE);
  assign mem_cyc_o   = in_bus;
  assign mem_we_o    = in_bus && we_q;
  assign mem_be_o    = in_bus ? be : 2'b00;
  assign mem_addr_o  = in_bus ? maddr : '0;
  assign mem_wdata_o = !in_bus ? 16'h0 : (two ? wsh[15:0] : {wsh[7:0], wsh[7:0]});
endmodule

// File: rtl/ws_bus_seq_chk.sv
module ws_bus_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_o,
  input logic       mem_cyc_o,
  input logic       mem_we_o,
  input logic [1:0] mem_be_o,
  input logic       mem_addr0_i
);
  // R7
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  // R7
  ready_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_cyc_o);
  // R7
  ready_after_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(mem_cyc_o));
  // R4
  pair_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cyc_o && mem_be_o == 2'b11) |-> !mem_addr0_i);
  // R2
  strobe_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cyc_o |-> (mem_be_o != 2'b00));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cyc_o |-> (mem_be_o == 2'b00 && !mem_we_o));
endmodule

bind ws_bus_seq ws_bus_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready_o), .mem_cyc_o(mem_cyc_o),
  .mem_we_o(mem_we_o), .mem_be_o(mem_be_o), .mem_addr0_i(mem_addr_o[0])
);

// File: tb/ws_bus_seq_test.sv
module ws_bus_seq_test;
  localparam int AW = 16;
  localparam int WW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req = 0, we = 0, wide = 0, ready, mem_cyc, mem_we;
  logic [AW-1:0] addr = '0, mem_addr;
  logic [1:0] size = '0, mem_be;
  logic [31:0] wdata = '0, rdata;
  logic [WW-1:0] wait_s = '0;
  logic [15:0] mem_wdata, mem_rdata;

  ws_bus_seq #(.ADDR_W(AW), .WS_W(WW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .wide_i(wide), .wait_i(wait_s),
    .ready_o(ready), .rdata_o(rdata), .mem_cyc_o(mem_cyc), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  logic [7:0] mem [256];
  logic cur_wide = 1'b0;
  always_comb begin
    if (cur_wide) mem_rdata = {mem[{mem_addr[7:1], 1'b1}], mem[{mem_addr[7:1], 1'b0}]};
    else          mem_rdata = {8'h00, mem[mem_addr[7:0]]};
  end

  int n_chk = 0, n_bad = 0, res_seen = 0, runs_done = 0, runs_exp = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  typedef struct {logic [15:0] a; logic [1:0] be; logic w; logic [15:0] wd; int len; string rq;} pc_t;
  typedef struct {logic w; logic [31:0] rd; int lat; string rq;} rs_t;
  pc_t pq[$];
  rs_t rq_q[$];

  // monitor
  bit run_on = 0, prev_rdy = 0;
  logic [15:0] r_a, r_wd;
  logic [1:0] r_be;
  logic r_we;
  int r_len = 0, busy = 0;

  task automatic finish_run();
    pc_t p;
    logic [15:0] m;
    runs_done++;
    run_on = 0;
    if (pq.size() == 0) begin
      chk(0, "R10", "unexpected bus cycle", {16'h0, r_a}, 32'h0);
      return;
    end
    p = pq.pop_front();
    chk(r_a == p.a && r_be == p.be && r_we == p.w, p.rq, "addr/strobe/we",
        {13'h0, r_we, r_be, r_a}, {13'h0, p.w, p.be, p.a});
    chk(r_len == p.len, "R2", "bus cycle length", r_len, p.len);
    if (r_we) begin
      m = {{8{r_be[1]}}, {8{r_be[0]}}};
      chk((r_wd & m) == (p.wd & m), "R6", "write lanes", {16'h0, r_wd & m}, {16'h0, p.wd & m});
      if (cur_wide) begin
        if (r_be[0]) mem[{r_a[7:1], 1'b0}] = r_wd[7:0];
        if (r_be[1]) mem[{r_a[7:1], 1'b1}] = r_wd[15:8];
      end else mem[r_a[7:0]] = r_wd[7:0];
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (run_on && !(mem_cyc && mem_addr == r_a && mem_be == r_be &&
                      mem_we == r_we && mem_wdata == r_wd))
        finish_run();
      if (mem_cyc) begin
        if (run_on) r_len++;
        else begin
          run_on = 1; r_a = mem_addr; r_be = mem_be; r_we = mem_we; r_wd = mem_wdata; r_len = 1;
        end
        busy++;
      end
      if (ready) begin
        rs_t r;
        chk(!prev_rdy, "R7", "ready longer than one clock", 1, 0);
        if (rq_q.size() == 0) chk(0, "R10", "unexpected ready", 1, 0);
        else begin
          r = rq_q.pop_front();
          chk(busy == r.lat, "R8", "bus clocks before ready", busy, r.lat);
          if (!r.w) chk(rdata == r.rd, r.rq, "read data", rdata, r.rd);
        end
        busy = 0;
        res_seen++;
      end
      prev_rdy = ready;
    end
  end

  // driver: predicts bus cycles from the requirements and pushes them
  task automatic access(input bit w, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input bit wd_bus, input int ws,
                        input bit hold, input bit perturb, input string rq);
    int n, left, k, cnt, target;
    logic [15:0] cur;
    logic [31:0] sh, exp_rd;
    pc_t p;
    rs_t r;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    cur = a; left = n; k = 0; cnt = 0;
    while (left > 0) begin
      bit two;
      two = 0;
      sh = wd >> (8 * k);
      p.w = w; p.len = ws + 1; p.rq = rq; p.a = cur; p.be = 2'b01;
      if (wd_bus) begin
        if (cur[0]) begin p.be = 2'b10; p.a = {cur[15:1], 1'b0}; end
        else if (left >= 2) begin p.be = 2'b11; two = 1; end
      end
      p.wd = two ? sh[15:0] : {sh[7:0], sh[7:0]};
      pq.push_back(p);
      cnt++;
      cur = cur + (two ? 16'd2 : 16'd1);
      left -= two ? 2 : 1;
      k += two ? 2 : 1;
    end
    exp_rd = '0;
    for (int j = 0; j < n; j++) begin
      logic [15:0] aj;
      aj = a + 16'(j);
      exp_rd[8*j +: 8] = mem[aj[7:0]];
    end
    r.w = w; r.rd = exp_rd; r.lat = cnt * (ws + 1); r.rq = rq;
    rq_q.push_back(r);
    runs_exp += cnt;
    target = res_seen + 1;
    @(negedge clk);
    cur_wide = wd_bus;
    req = 1; we = w; addr = a; size = sz; wdata = wd; wide = wd_bus; wait_s = WW'(ws);
    @(negedge clk);
    if (!hold) req = 0;
    if (perturb) begin wait_s = ~WW'(ws); wide = ~wd_bus; end
    while (res_seen < target) @(posedge clk);
    @(negedge clk);
    req = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R1 in reset
    chk(!ready && !mem_cyc && !mem_we && mem_be == 2'b00, "R1", "outputs in reset",
        {28'h0, ready, mem_cyc, mem_be}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk(!ready && !mem_cyc && !mem_we && mem_be == 2'b00, "R1", "outputs after reset",
        {28'h0, ready, mem_cyc, mem_be}, 32'h0);
    // R3 8-bit bus
    access(1, 16'h0010, 2'b10, 32'hA1B2C3D4, 0, 0, 0, 0, "R3");
    access(0, 16'h0010, 2'b10, 32'h0, 0, 2, 0, 0, "R3");
    access(0, 16'h0041, 2'b01, 32'h0, 0, 1, 0, 0, "R3");
    // R4 16-bit aligned
    access(1, 16'h0020, 2'b01, 32'h00005A6B, 1, 1, 0, 0, "R4");
    access(0, 16'h0010, 2'b10, 32'h0, 1, 0, 0, 0, "R4");
    access(0, 16'h0020, 2'b00, 32'h0, 1, 3, 0, 0, "R4");
    access(0, 16'h0020, 2'b01, 32'h0, 1, 0, 0, 0, "R6");
    // R5 16-bit unaligned
    access(0, 16'h0011, 2'b00, 32'h0, 1, 0, 0, 0, "R5");
    access(1, 16'h0031, 2'b10, 32'h11223344, 1, 1, 0, 0, "R5");
    access(0, 16'h0031, 2'b10, 32'h0, 1, 3, 0, 0, "R5");
    access(0, 16'h0013, 2'b01, 32'h0, 1, 0, 0, 0, "R5");
    access(1, 16'h0051, 2'b01, 32'h0000CAFE, 1, 2, 0, 0, "R5");
    access(0, 16'h0050, 2'b10, 32'h0, 0, 0, 0, 0, "R6");
    // R6 size code 3 acts as 4 bytes
    access(0, 16'h0031, 2'b11, 32'h0, 1, 0, 0, 0, "R6");
    // R9 settings changed mid-access
    access(0, 16'h0033, 2'b10, 32'h0, 1, 2, 0, 1, "R9");
    access(1, 16'h0060, 2'b10, 32'h99887766, 0, 0, 0, 1, "R9");
    access(0, 16'h0060, 2'b10, 32'h0, 0, 5, 0, 1, "R9");
    // R10 request held through ready
    access(0, 16'h0060, 2'b10, 32'h0, 1, 1, 1, 0, "R10");
    repeat (8) @(negedge clk);
    chk(runs_done == runs_exp && pq.size() == 0, "R10", "bus cycles issued",
        runs_done, runs_exp);
    chk(!mem_cyc && !ready, "R10", "idle after held request", {30'h0, mem_cyc, ready}, 32'h0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog: ready never arrived act=0 exp=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule